// File: doc/BRIEF.md
# Cursor Settings Register Block

This block stores the settings of a hardware mouse pointer for a display pipeline. It holds the image base offset, the screen position, the hotspot offset and two colours. The image fetcher and the overlay logic downstream read these values. Software writes the registers one 32-bit word at a time through a simple write port with byte enables. Any subset of byte lanes may be written.

Bit 31 of the offset register acts as an update lock. A write to the offset, position or hotspot register can set it. While the lock is held, changes to the image parameters do not request a new image fetch. Releasing the lock through a position or hotspot write requests the fetch. The block emits a one-cycle "redefine" pulse whenever the cursor image must be fetched again. It emits a one-cycle "position update" pulse when an unlocked position write lands. Both pulses are gated by the cursor enable input.

The lock is a two-state machine with states LOCK_OPEN and LOCK_HELD. The *grab* transition (LOCK_OPEN to LOCK_HELD) fires on any write whose merged bit 31 is set. The *release* transition (LOCK_HELD to LOCK_OPEN) fires on a write whose merged bit 31 is clear.

Top module: `cursor_regs`

## Requirements
- R1: After reset every register output reads zero, the lock is open and neither pulse is raised.
- R2: The offset register (select code 0) keeps only the bits under mask 0x87fffff0. Its bit 31 is the shared lock and reads back on `cur_offset[31]`.
- R3: An offset write raises `redefine` only when the new masked value differs from the stored one, lock bit included.
- R4: The position register (select code 1) keeps bits under 0x3fff0fff, with the horizontal coordinate in bits 29:16 and the vertical coordinate in bits 11:0. The hotspot register (select code 2) keeps bits under 0x003f003f.
- R5: In a position or hotspot write, bit 31 is the written byte-3 bit 7 when byte 3 is enabled, and otherwise the current lock. If that bit is set, the lock becomes held. If it is clear while the lock was held, the lock is released and `redefine` is raised.
- R6: Colour 0 (select code 3) keeps bits 23:0, with bits 31:24 reading zero, and raises `redefine` only when its stored value changes.
- R7: Every write to colour 1 (select code 4), whatever the byte enables or data, raises `redefine`. Colour 1 keeps bits 23:0.
- R8: A position write raises `pos_update` when the merged bit 31 is clear.
- R9: Byte enable bit i selects data bits 8i+7:8i. Bytes that are not enabled keep their stored value, and masking and comparison apply to the merged word.
- R10: Register values and pulses appear in the cycle after the write edge. A pulse is raised only if `cur_enable` was high in the write cycle. Without a write, no pulse is raised.
- R11: Writes with select codes 5 to 7 change no register and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Register select code |
| wr_be | input | 4 | Byte enables |
| wr_data | input | 32 | Write data |
| cur_enable | input | 1 | Cursor enable, gates both pulses |
| cur_offset | output | 32 | Image offset, bit 31 is the lock |
| cur_pos | output | 32 | Position (horizontal 29:16, vertical 11:0) |
| cur_hot | output | 32 | Hotspot offset |
| cur_clr0 | output | 32 | Colour 0 (bits 23:0) |
| cur_clr1 | output | 32 | Colour 1 (bits 23:0) |
| redefine | output | 1 | Image refetch request pulse |
| pos_update | output | 1 | Position update pulse |

## Verification
The hardest case to reach is a partial position or hotspot write that leaves byte 3 disabled while the lock is held. Here the lock must survive, no position pulse may appear, and the lower bytes must still change. This interacts with a later full write that releases the lock and must produce exactly one redefine. Directed sequences first grab the lock through the offset register, then issue the lane-restricted writes, then release through the hotspot register. A long run of random selects, byte enables and enable levels then checks every output against a behavioural model on every clock.

// File: rtl/curs_pkg.sv
package curs_pkg;
    localparam int DW     = 32;
    localparam int NBYTES = DW / 8;
    localparam int SEL_W  = 3;

    localparam logic [DW-1:0] OFF_MASK = 32'h87ff_fff0;
    localparam logic [DW-1:0] POS_MASK = 32'h3fff_0fff;
    localparam logic [DW-1:0] HOT_MASK = 32'h003f_003f;
    localparam logic [DW-1:0] CLR_MASK = 32'h00ff_ffff;

    typedef enum logic [SEL_W-1:0] {
        SEL_OFF  = 3'd0,
        SEL_POS  = 3'd1,
        SEL_HOT  = 3'd2,
        SEL_CLR0 = 3'd3,
        SEL_CLR1 = 3'd4
    } sel_e;

    typedef enum logic {
        LOCK_OPEN = 1'b0,
        LOCK_HELD = 1'b1
    } lock_e;

    typedef struct packed {
        logic redef;
        logic pos_upd;
    } evt_t;
endpackage

// File: rtl/curs_byte_merge.sv
module curs_byte_merge #(
    parameter int NB = 4
) (
    input  logic [NB*8-1:0] old_i,
    input  logic [NB*8-1:0] new_i,
    input  logic [NB-1:0]   be_i,
    output logic [NB*8-1:0] out_o
);
    generate
        for (genvar g = 0; g < NB; g++) begin : g_lane
            assign out_o[g*8 +: 8] = be_i[g] ? new_i[g*8 +: 8] : old_i[g*8 +: 8];
        end
    endgenerate
endmodule

// File: rtl/curs_lock_fsm.sv
module curs_lock_fsm
    import curs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic grab_i,
    input  logic release_i,
    output logic locked_o
);
    lock_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOCK_OPEN: if (grab_i)    state_d = LOCK_HELD;
            LOCK_HELD: if (release_i) state_d = LOCK_OPEN;
            default:                  state_d = LOCK_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LOCK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        locked_o = (state_q == LOCK_HELD);
    end

    AST_GRAB_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        grab_i |=> locked_o); // R5
    AST_RELEASE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && !grab_i) |=> !locked_o); // R5
endmodule

// File: rtl/curs_evt_out.sv
module curs_evt_out
    import curs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  evt_t evt_i,
    input  logic en_i,
    output logic redef_o,
    output logic pos_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redef_o <= 1'b0;
            pos_o   <= 1'b0;
        end else begin
            redef_o <= evt_i.redef   & en_i;
            pos_o   <= evt_i.pos_upd & en_i;
        end
    end

    AST_REDEF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        redef_o |-> $past(en_i)); // R10
    AST_POS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        pos_o |-> $past(en_i)); // R10
endmodule

// File: rtl/cursor_regs.sv
module cursor_regs
    import curs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [NBYTES-1:0] wr_be,
    input  logic [DW-1:0]    wr_data,
    input  logic             cur_enable,
    output logic [DW-1:0]    cur_offset,
    output logic [DW-1:0]    cur_pos,
    output logic [DW-1:0]    cur_hot,
    output logic [DW-1:0]    cur_clr0,
    output logic [DW-1:0]    cur_clr1,
    output logic             redefine,
    output logic             pos_update
);
    localparam logic [DW-1:0] LOCK_BIT = {1'b1, {(DW-1){1'b0}}};

    logic [DW-2:0] off_q;
    logic [DW-1:0] pos_q, hot_q, clr0_q, clr1_q;
    logic          locked;
    logic [DW-1:0] old_val, merged, masked;
    logic          grab, rel;
    evt_t          evt;

    // Current value of the addressed register, lock merged in where shared
    always_comb begin
        unique case (wr_sel)
            SEL_OFF:  old_val = {locked, off_q};
            SEL_POS:  old_val = pos_q | (locked ? LOCK_BIT : '0);
            SEL_HOT:  old_val = hot_q | (locked ? LOCK_BIT : '0);
            SEL_CLR0: old_val = clr0_q;
            SEL_CLR1: old_val = clr1_q;
            default:  old_val = '0;
        endcase
    end

    curs_byte_merge #(.NB(NBYTES)) u_merge (
        .old_i (old_val),
        .new_i (wr_data),
        .be_i  (wr_be),
        .out_o (merged)
    );

    always_comb begin
        unique case (wr_sel)
            SEL_OFF:  masked = merged & OFF_MASK;
            SEL_POS:  masked = merged & POS_MASK;
            SEL_HOT:  masked = merged & HOT_MASK;
            SEL_CLR0: masked = merged & CLR_MASK;
            SEL_CLR1: masked = merged & CLR_MASK;
            default:  masked = '0;
        endcase
    end

    // Event and lock decisions for the current write
    always_comb begin
        evt  = '0;
        grab = 1'b0;
        rel  = 1'b0;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_OFF: begin
                    evt.redef = (masked != old_val);
                    grab      = masked[DW-1];
                    rel       = locked & ~masked[DW-1];
                end
                SEL_POS, SEL_HOT: begin
                    if (merged[DW-1]) begin
                        grab = 1'b1;
                    end else if (locked) begin
                        rel       = 1'b1;
                        evt.redef = 1'b1;
                    end
                    evt.pos_upd = (wr_sel == SEL_POS) & ~merged[DW-1];
                end
                SEL_CLR0: evt.redef = (masked != old_val);
                SEL_CLR1: evt.redef = 1'b1;
                default: ;
            endcase
        end
    end

    curs_lock_fsm u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .grab_i    (grab),
        .release_i (rel),
        .locked_o  (locked)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q  <= '0;
            pos_q  <= '0;
            hot_q  <= '0;
            clr0_q <= '0;
            clr1_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_OFF:  off_q  <= masked[DW-2:0];
                SEL_POS:  pos_q  <= masked;
                SEL_HOT:  hot_q  <= masked;
                SEL_CLR0: clr0_q <= masked;
                SEL_CLR1: clr1_q <= masked;
                default: ;
            endcase
        end
    end

    curs_evt_out u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt),
        .en_i    (cur_enable),
        .redef_o (redefine),
        .pos_o   (pos_update)
    );

    always_comb begin
        cur_offset = {locked, off_q};
        cur_pos    = pos_q;
        cur_hot    = hot_q;
        cur_clr0   = clr0_q;
        cur_clr1   = clr1_q;
    end

    AST_CLR1_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CLR1 && cur_enable) |=> redefine); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!redefine && !pos_update)); // R10
    AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel > SEL_CLR1) |=> ($stable(cur_offset) && $stable(cur_pos)
            && $stable(cur_hot) && $stable(cur_clr0) && $stable(cur_clr1) && !redefine)); // R11
    AST_UNLOCK_REDEF: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cur_offset[DW-1]) && $past(cur_enable)) |-> redefine); // R5
    AST_POS_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        pos_update |-> !cur_offset[DW-1]); // R8
endmodule

// File: tb/sim_cursor_regs.sv
`timescale 1ns/1ps
module sim_cursor_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic        cur_enable = 1'b0;
    logic [31:0] cur_offset, cur_pos, cur_hot, cur_clr0, cur_clr1;
    logic        redefine, pos_update;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference state
    logic [31:0] m_off = '0, m_pos = '0, m_hot = '0, m_c0 = '0, m_c1 = '0;
    logic        m_rd = 1'b0, m_pu = 1'b0;

    always #10 clk = ~clk;

    cursor_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
        .wr_data(wr_data), .cur_enable(cur_enable), .cur_offset(cur_offset),
        .cur_pos(cur_pos), .cur_hot(cur_hot), .cur_clr0(cur_clr0), .cur_clr1(cur_clr1),
        .redefine(redefine), .pos_update(pos_update)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "offset", cur_offset, m_off);
        chk(tag, "position", cur_pos, m_pos);
        chk(tag, "hotspot", cur_hot, m_hot);
        chk(tag, "colour0", cur_clr0, m_c0);
        chk(tag, "colour1", cur_clr1, m_c1);
        chk(tag, "redefine", {31'b0, redefine}, {31'b0, m_rd});
        chk(tag, "pos_update", {31'b0, pos_update}, {31'b0, m_pu});
    endtask

    // Drive one cycle from negedge, advance the model at the edge, compare at the next negedge
    task automatic step(input logic w, input logic [2:0] a, input logic [3:0] be,
                        input logic [31:0] d, input logic en, input string tag);
        logic [31:0] base, mg;
        logic [31:0] n_off, n_pos, n_hot, n_c0, n_c1;
        logic        nrd, npu, lk;
        wr_en = w; wr_sel = a; wr_be = be; wr_data = d; cur_enable = en;
        lk = m_off[31];
        n_off = m_off; n_pos = m_pos; n_hot = m_hot; n_c0 = m_c0; n_c1 = m_c1;
        nrd = 1'b0; npu = 1'b0;
        case (a)
            3'd0: base = m_off;
            3'd1: base = m_pos | {lk, 31'b0};
            3'd2: base = m_hot | {lk, 31'b0};
            3'd3: base = m_c0;
            3'd4: base = m_c1;
            default: base = '0;
        endcase
        mg = base;
        for (int i = 0; i < 4; i++) if (be[i]) mg[i*8 +: 8] = d[i*8 +: 8];
        if (w) begin
            case (a)
                3'd0: begin n_off = mg & 32'h87ff_fff0; nrd = (n_off != m_off); end
                3'd1, 3'd2: begin
                    if (a == 3'd1) n_pos = mg & 32'h3fff_0fff;
                    else           n_hot = mg & 32'h003f_003f;
                    if (mg[31]) n_off[31] = 1'b1;
                    else if (lk) begin n_off[31] = 1'b0; nrd = 1'b1; end
                    if (a == 3'd1) npu = !mg[31];
                end
                3'd3: begin n_c0 = mg & 32'h00ff_ffff; nrd = (n_c0 != m_c0); end
                3'd4: begin n_c1 = mg & 32'h00ff_ffff; nrd = 1'b1; end
                default: ;
            endcase
        end
        @(posedge clk);
        m_off = n_off; m_pos = n_pos; m_hot = n_hot; m_c0 = n_c0; m_c1 = n_c1;
        m_rd = nrd & en; m_pu = npu & en;
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        compare_all("R1");
        chk("R1", "reset offset", cur_offset, 32'h0);

        // R2/R3: offset masking and grab of the lock
        step(1, 3'd0, 4'hf, 32'hffff_ffff, 1, "R2");
        chk("R2", "offset mask", cur_offset, 32'h87ff_fff0);
        chk("R3", "redefine on change", {31'b0, redefine}, 32'h1);
        step(1, 3'd0, 4'hf, 32'hffff_ffff, 1, "R3");
        chk("R3", "no redefine same", {31'b0, redefine}, 32'h0);

        // R4/R5/R8: locked position write, no pulse
        step(1, 3'd1, 4'hf, 32'hffff_ffff, 1, "R4");
        chk("R4", "position mask", cur_pos, 32'h3fff_0fff);
        chk("R8", "no pos pulse when locked", {31'b0, pos_update}, 32'h0);
        // R9: byte 3 disabled keeps the lock, lower bytes change
        step(1, 3'd1, 4'h7, 32'h0000_0000, 1, "R9");
        chk("R9", "partial write", cur_pos, 32'h3f00_0000);
        chk("R5", "lock kept", {31'b0, cur_offset[31]}, 32'h1);
        // R5: release through hotspot
        step(1, 3'd2, 4'hf, 32'h0012_3456, 1, "R5");
        chk("R4", "hotspot mask", cur_hot, 32'h0012_0016);
        chk("R5", "release redefine", {31'b0, redefine}, 32'h1);
        chk("R5", "lock open", {31'b0, cur_offset[31]}, 32'h0);
        // R8: unlocked position write pulses
        step(1, 3'd1, 4'hf, 32'h0123_0456, 1, "R8");
        chk("R8", "pos pulse", {31'b0, pos_update}, 32'h1);
        // R10: enable low gates pulses
        step(1, 3'd1, 4'hf, 32'h0001_0002, 0, "R10");
        chk("R10", "gated pulse", {31'b0, pos_update}, 32'h0);
        step(0, 3'd1, 4'hf, 32'h0, 1, "R10");
        // R6: colour 0
        step(1, 3'd3, 4'hf, 32'h11ab_cdef, 1, "R6");
        chk("R6", "colour0 mask", cur_clr0, 32'h00ab_cdef);
        step(1, 3'd3, 4'hf, 32'h22ab_cdef, 1, "R6");
        chk("R6", "colour0 no change", {31'b0, redefine}, 32'h0);
        // R7: colour 1 always redefines
        step(1, 3'd4, 4'hf, 32'h0055_5555, 1, "R7");
        step(1, 3'd4, 4'h0, 32'h0, 1, "R7");
        chk("R7", "colour1 forced", {31'b0, redefine}, 32'h1);
        // R11: unmapped select
        step(1, 3'd5, 4'hf, 32'hffff_ffff, 1, "R11");
        step(1, 3'd7, 4'hf, 32'hffff_ffff, 1, "R11");
        chk("R11", "unmapped no pulse", {31'b0, redefine}, 32'h0);

        // Random traffic against the model
        for (int k = 0; k < 600; k++) begin
            automatic logic [31:0] r1 = $urandom();
            automatic logic [31:0] r2 = $urandom();
            step(r1[0] | r1[1], r1[4:2], r1[8:5], r2, r1[9] | r1[10], "R9");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule